// File: doc/BRIEF.md
# Microwire Serial Slave Receiver

This block is the slave end of a three-wire half-duplex serial link. The master drives a serial clock, an active-low select and a data line. While the select is low the slave takes in a fixed 8-bit control word, most significant bit first. It then returns one zero turnaround bit, followed by a reply word whose length can be set from 4 to 16 bits, also most significant bit first. The slave samples its data input on serial-clock rising edges and changes its reply output on falling edges. If the select stays low after the last reply bit, the next control word follows at once, and frames can repeat without a gap.

All three serial inputs pass through a two-flop synchronizer into the system clock domain, and every edge is found there. The system clock must run at least eight times faster than the serial clock. A frame only begins once the select timing has been qualified. The select must fall at least one serial-clock period after the last rising edge. It must also stay low for at least two periods before the first sampling edge. The period is given in system-clock cycles on a plain control pin. A violation raises a sticky flag, and the slave then ignores the link until the select goes high.

Software-side logic loads the reply through a valid/ready input that holds one word. A word is accepted on any cycle where both valid and ready are high. Ready stays low until the slave launches that word's first bit, so the loader is held back while a word is pending. The control-word output is a one-cycle valid pulse with data and has no ready: the serial master cannot be stalled, so the consumer must take each word in the cycle it appears.

Top module: `mw_slave`

## Requirements
- R1: After the 8th qualified rising edge of a frame, `ctl_valid` pulses for exactly one cycle and `ctl_data` holds the 8 sampled bits. The first bit received sits in bit 7.
- R2: The select must be low for at least 2×`sk_period` system cycles before the first rising edge after it falls. A shorter setup sets the sticky `err_setup`, and no control word is reported until the select has gone high again.
- R3: If the select falls less than `sk_period` system cycles after the previous rising edge, the sticky `err_hold` is set and the frame is ignored until the select goes high.
- R4: The reply output is 0 on the falling edge after the 8th rising edge (turnaround). On the next L falling edges it carries the L reply bits, most significant first. L is `rep_len` sampled on the frame's first rising edge, with values below 4 taken as 4 and values above 16 taken as 16. Changes to `rep_len` later in the frame have no effect.
- R5: While the select stays low, the rising edge right after the last reply bit's sampling edge starts the next control word. No new setup check is made.
- R6: `so_oe` is low whenever `cs_n` is high and high whenever `cs_n` is low. `so` is 0 whenever no qualified frame is in progress.
- R7: `rep_ready` is high while the single holding slot is empty. A word is taken when `rep_valid` and `rep_ready` are both high. The slot stays full until that word's first bit is launched, and is then free again.
- R8: If the slot is empty when the reply's first bit is due, the whole reply is sent as zeros and the sticky `underrun` flag is set.
- R9: A select rising before the 8th bit aborts the frame. No control word is reported, and a loaded reply word stays pending for the next frame.
- R10: After reset `ctl_valid`, `err_setup`, `err_hold` and `underrun` are 0 and `rep_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select from the master |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial reply data |
| so_oe | output | 1 | Reply driver enable (high drives `so` onto the line) |
| sk_period | input | CW (12) | Serial-clock period in system cycles, used for the setup and hold checks |
| rep_len | input | LW (5) | Requested reply length in bits |
| rep_valid | input | 1 | Reply word offered |
| rep_ready | output | 1 | Holding slot empty |
| rep_data | input | MAX_LEN (16) | Reply word, right-aligned |
| ctl_valid | output | 1 | One-cycle pulse: control word complete |
| ctl_data | output | CTL_W (8) | Received control word |
| err_setup | output | 1 | Sticky select setup violation |
| err_hold | output | 1 | Sticky select hold violation |
| underrun | output | 1 | Sticky: a reply was due with no word loaded |

## Verification
If the frame position counter is off by one, every reply is shifted by one bit. The turnaround check then fails on the first frame, within about ten serial-clock periods of the select falling. In continuous frames the second control word also comes out misaligned. A qualifier stuck in the wrong state either drops the control-word pulse or produces one after a timing violation, and the queue-based monitor flags this at the 8th edge. A holding slot that fails to clear or to fill shows up on `rep_ready` within a cycle of the launch, or as a zero reply together with an `underrun` flag that should not be set.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    Q_IDLE  = 2'd0,
    Q_ARMED = 2'd1,
    Q_RUN   = 2'd2,
    Q_BAD   = 2'd3
  } qual_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[0] <= INIT;
        else        stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[g] <= INIT;
        else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mw_qual.sv
module mw_qual
  import mw_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sk_rise,
  input  logic          cs_hi,
  input  logic          cs_fall,
  input  logic [CW-1:0] sk_period,
  output logic          start,
  output logic          err_setup,
  output logic          err_hold
);
  qual_state_e st;
  logic [CW-1:0] since_rise;
  logic [CW:0]   setup_cnt;
  logic          setup_ok, hold_ok;

  assign setup_ok = setup_cnt >= {sk_period, 1'b0};
  assign hold_ok  = !sk_rise && (since_rise >= sk_period);
  assign start    = (st == Q_ARMED) && !cs_hi && sk_rise && setup_ok;

  // cycles since the latest synchronized rising edge, saturating
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                since_rise <= '1;
    else if (sk_rise)          since_rise <= CW'(1);
    else if (since_rise != '1) since_rise <= since_rise + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= Q_IDLE;
      setup_cnt <= '0;
      err_setup <= 1'b0;
      err_hold  <= 1'b0;
    end else if (cs_hi) begin
      st <= Q_IDLE;
    end else begin
      case (st)
        Q_IDLE: if (cs_fall) begin
          if (hold_ok) begin
            st        <= Q_ARMED;
            setup_cnt <= (CW+1)'(1);
          end else begin
            st       <= Q_BAD;
            err_hold <= 1'b1;
          end
        end
        Q_ARMED: if (sk_rise) begin
          if (setup_ok) st <= Q_RUN;
          else begin
            st        <= Q_BAD;
            err_setup <= 1'b1;
          end
        end else if (setup_cnt != '1) begin
          setup_cnt <= setup_cnt + 1'b1;
        end
        default: st <= st;
      endcase
    end

  assert_setup_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_setup |=> err_setup);
  assert_hold_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_hold |=> err_hold);
  assert_short_hold_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == Q_IDLE && cs_fall && !cs_hi && since_rise < sk_period) |=> (err_hold && st == Q_BAD));
  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/mw_rbuf.sv
module mw_rbuf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic          held_valid,
  output logic [DW-1:0] held_data
);
  logic full;

  assign in_ready   = !full;
  assign held_valid = full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full      <= 1'b0;
      held_data <= '0;
    end else if (in_valid && !full) begin
      full      <= 1'b1;
      held_data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end

  assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_kept_until_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(held_data)));
  assert_take_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
endmodule

// File: rtl/mw_frame.sv
module mw_frame #(
  parameter int CTL_W   = 8,
  parameter int MAX_LEN = 16,
  parameter int MIN_LEN = 4,
  parameter int LW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sk_rise,
  input  logic               sk_fall,
  input  logic               si,
  input  logic               cs_hi,
  input  logic               start,
  input  logic [LW-1:0]      rep_len,
  input  logic               buf_valid,
  input  logic [MAX_LEN-1:0] buf_data,
  output logic               buf_take,
  output logic               ctl_valid,
  output logic [CTL_W-1:0]   ctl_data,
  output logic               so_bit,
  output logic               underrun
);
  localparam int FRAME_MAX = CTL_W + 1 + MAX_LEN;
  localparam int PW = $clog2(FRAME_MAX + 1);
  localparam logic [PW-1:0] P_CTL    = PW'(CTL_W);
  localparam logic [PW-1:0] P_LAUNCH = PW'(CTL_W + 1);

  logic               frame_on;
  logic [PW-1:0]      pos, eff_pos, end_pos;
  logic [LW-1:0]      len_q, len_req;
  logic [CTL_W-1:0]   ctl_sh;
  logic [MAX_LEN-1:0] rep_sh, aligned;
  logic [LW-1:0]      shamt;
  logic               do_rise, do_fall, last;

  always_comb begin
    if (rep_len < LW'(MIN_LEN))      len_req = LW'(MIN_LEN);
    else if (rep_len > LW'(MAX_LEN)) len_req = LW'(MAX_LEN);
    else                             len_req = rep_len;
  end

  assign eff_pos = start ? '0 : pos;
  assign end_pos = P_CTL + PW'(len_q);
  assign last    = (eff_pos == end_pos);
  assign do_rise = start || (frame_on && sk_rise && !cs_hi);
  assign do_fall = frame_on && sk_fall && !cs_hi && !do_rise;
  assign shamt   = LW'(MAX_LEN) - len_q;
  assign aligned = buf_valid ? (buf_data << shamt) : '0;
  assign buf_take = do_fall && (pos == P_LAUNCH) && buf_valid;
  assign so_bit  = so_q;

  logic so_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_on  <= 1'b0;
      pos       <= '0;
      len_q     <= LW'(MIN_LEN);
      ctl_sh    <= '0;
      ctl_data  <= '0;
      ctl_valid <= 1'b0;
      rep_sh    <= '0;
      so_q      <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      ctl_valid <= 1'b0;
      if (cs_hi) begin
        frame_on <= 1'b0;
        pos      <= '0;
        so_q     <= 1'b0;
      end else begin
        if (start) frame_on <= 1'b1;
        if (do_rise) begin
          if (eff_pos < P_CTL) ctl_sh <= {ctl_sh[CTL_W-2:0], si};
          if (eff_pos == P_CTL - 1'b1) begin
            ctl_valid <= 1'b1;
            ctl_data  <= {ctl_sh[CTL_W-2:0], si};
          end
          if (eff_pos == '0) len_q <= len_req;
          pos <= (eff_pos != '0 && last) ? '0 : eff_pos + 1'b1;
        end else if (do_fall) begin
          if (pos == P_LAUNCH) begin
            so_q   <= aligned[MAX_LEN-1];
            rep_sh <= aligned << 1;
            if (!buf_valid) underrun <= 1'b1;
          end else if (pos > P_LAUNCH && pos <= end_pos) begin
            so_q   <= rep_sh[MAX_LEN-1];
            rep_sh <= rep_sh << 1;
          end else begin
            so_q <= 1'b0;
          end
        end
      end
    end

  assert_ctl_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid);
  assert_quiet_outside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |-> !so_q);
  assert_pos_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(CTL_W + MAX_LEN));
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LW'(MIN_LEN)) && (len_q <= LW'(MAX_LEN)));
endmodule

// File: rtl/mw_slave.sv
module mw_slave #(
  parameter int CTL_W   = 8,
  parameter int MAX_LEN = 16,
  parameter int MIN_LEN = 4,
  parameter int CW      = 12,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sk,
  input  logic               cs_n,
  input  logic               si,
  output logic               so,
  output logic               so_oe,
  input  logic [CW-1:0]      sk_period,
  input  logic [LW-1:0]      rep_len,
  input  logic               rep_valid,
  output logic               rep_ready,
  input  logic [MAX_LEN-1:0] rep_data,
  output logic               ctl_valid,
  output logic [CTL_W-1:0]   ctl_data,
  output logic               err_setup,
  output logic               err_hold,
  output logic               underrun
);
  logic [2:0] synced;
  logic sk_s, cs_s, si_s, sk_d, cs_d;
  logic sk_rise, sk_fall, cs_fall;
  logic start, buf_valid, buf_take;
  logic [MAX_LEN-1:0] buf_data;

  mw_sync #(.W(3), .STAGES(2), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sk, cs_n, si}), .q(synced));

  assign {sk_s, cs_s, si_s} = synced;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sk_d <= 1'b0;
      cs_d <= 1'b1;
    end else begin
      sk_d <= sk_s;
      cs_d <= cs_s;
    end

  assign sk_rise = sk_s && !sk_d;
  assign sk_fall = !sk_s && sk_d;
  assign cs_fall = !cs_s && cs_d;
  assign so_oe   = !cs_n;

  mw_qual #(.CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .sk_rise(sk_rise), .cs_hi(cs_s),
    .cs_fall(cs_fall), .sk_period(sk_period), .start(start),
    .err_setup(err_setup), .err_hold(err_hold));

  mw_rbuf #(.DW(MAX_LEN)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .in_valid(rep_valid), .in_data(rep_data),
    .in_ready(rep_ready), .take(buf_take), .held_valid(buf_valid),
    .held_data(buf_data));

  mw_frame #(.CTL_W(CTL_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LW(LW)) u_frame (
    .clk(clk), .rst_n(rst_n), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .si(si_s), .cs_hi(cs_s), .start(start), .rep_len(rep_len),
    .buf_valid(buf_valid), .buf_data(buf_data), .buf_take(buf_take),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .so_bit(so),
    .underrun(underrun));

  assert_no_word_when_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !ctl_valid);
  assert_no_take_when_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !buf_take);
endmodule

// File: tb/sim_mw_slave.sv
`timescale 1ns/1ps
module sim_mw_slave;
  localparam int SKP = 16;

  logic clk = 1'b0;
  logic rst_n, sk, cs_n, si, rep_valid;
  logic [11:0] sk_period;
  logic [4:0]  rep_len;
  logic [15:0] rep_data;
  logic so, so_oe, rep_ready, ctl_valid, err_setup, err_hold, underrun;
  logic [7:0] ctl_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  mw_slave u0 (
    .clk(clk), .rst_n(rst_n), .sk(sk), .cs_n(cs_n), .si(si), .so(so),
    .so_oe(so_oe), .sk_period(sk_period), .rep_len(rep_len),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_data(rep_data),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data), .err_setup(err_setup),
    .err_hold(err_hold), .underrun(underrun));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_cycle();
    sk = 1'b1;
    wait_n(SKP/2);
    sk = 1'b0;
    wait_n(SKP/2);
  endtask

  // scoreboard monitor: control words in order
  always @(negedge clk) begin
    if (rst_n && ctl_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2/R9 unexpected control word", int'(ctl_data), 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(ctl_data == e, "R1 control word", int'(ctl_data), int'(e));
      end
    end
  end

  task automatic load_reply(input logic [15:0] d);
    while (!rep_ready) @(negedge clk);
    rep_valid = 1'b1;
    rep_data  = d;
    @(negedge clk);
    rep_valid = 1'b0;
    check(rep_ready == 1'b0, "R7 slot full after accept", int'(rep_ready), 0);
  endtask

  // full qualified frame: control bits, turnaround, reply bits
  task automatic run_frame(input logic [7:0] ctl, input logic [4:0] len_req,
                           input int len, input logic [15:0] rep);
    expq.push_back(ctl);
    for (int i = 0; i < 9 + len; i++) begin
      if (i == 0) rep_len = len_req;
      si = (i < 8) ? ctl[7-i] : 1'b0;
      if (i == 8) check(so == 1'b0, "R4 turnaround zero", int'(so), 0);
      if (i >= 9) check(so == rep[len-1-(i-9)], "R4 reply bit", int'(so), int'(rep[len-1-(i-9)]));
      sk_cycle();
      if (i == 0) rep_len = 5'd1; // R4: later change ignored
    end
  endtask

  // rises with no frame expected: output must stay 0
  task automatic dead_rises(input logic [7:0] ctl, input int n);
    for (int i = 0; i < n; i++) begin
      si = ctl[7 - (i % 8)];
      check(so == 1'b0, "R6 idle output zero", int'(so), 0);
      sk_cycle();
    end
  endtask

  task automatic select_low();
    cs_n = 1'b0;
    wait_n(2);
    check(so_oe == 1'b1, "R6 driver enabled", int'(so_oe), 1);
    wait_n(2 * SKP + 8);
  endtask

  task automatic select_high();
    wait_n(4);
    cs_n = 1'b1;
    wait_n(2);
    check(so_oe == 1'b0, "R6 driver released", int'(so_oe), 0);
    wait_n(SKP + 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sk = 1'b0; cs_n = 1'b1; si = 1'b0;
    rep_valid = 1'b0; rep_data = '0; rep_len = 5'd8; sk_period = 12'(SKP);
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R10 reset state
    check(ctl_valid == 1'b0, "R10 ctl_valid", int'(ctl_valid), 0);
    check(err_setup == 1'b0, "R10 err_setup", int'(err_setup), 0);
    check(err_hold == 1'b0, "R10 err_hold", int'(err_hold), 0);
    check(underrun == 1'b0, "R10 underrun", int'(underrun), 0);
    check(rep_ready == 1'b1, "R10 rep_ready", int'(rep_ready), 1);
    check(so_oe == 1'b0, "R6 released at reset", int'(so_oe), 0);

    // R1 R4 R7: one plain frame
    load_reply(16'h00A5);
    select_low();
    run_frame(8'hC3, 5'd8, 8, 16'h00A5);
    check(rep_ready == 1'b1, "R7 slot freed at launch", int'(rep_ready), 1);
    check(underrun == 1'b0, "R8 no underrun when loaded", int'(underrun), 0);
    select_high();

    // R5: continuous frames with different lengths
    load_reply(16'h000B);
    select_low();
    fork
      begin
        run_frame(8'h5A, 5'd4, 4, 16'h000B);
        run_frame(8'h81, 5'd12, 12, 16'h0A5C);
      end
      load_reply(16'h0A5C);
    join
    select_high();
    check(expq.size() == 0, "R5 both continuous words seen", expq.size(), 0);

    // R4 clamping: below minimum and above maximum
    load_reply(16'h0009);
    select_low();
    run_frame(8'h3C, 5'd2, 4, 16'h0009);
    select_high();
    load_reply(16'hB2E7);
    select_low();
    run_frame(8'hF0, 5'd20, 16, 16'hB2E7);
    select_high();

    // R9: abort keeps the loaded word
    load_reply(16'h0036);
    select_low();
    dead_rises(8'hFF, 5);
    select_high();
    check(rep_ready == 1'b0, "R9 word still pending after abort", int'(rep_ready), 0);
    check(underrun == 1'b0, "R9 abort is no underrun", int'(underrun), 0);
    select_low();
    run_frame(8'h66, 5'd6, 6, 16'h0036);
    select_high();

    // R8: empty slot gives zeros and underrun
    select_low();
    run_frame(8'h99, 5'd8, 8, 16'h0000);
    select_high();
    check(underrun == 1'b1, "R8 underrun flag", int'(underrun), 1);

    // R3: select falls too soon after a rising edge
    sk = 1'b1; wait_n(4); sk = 1'b0; wait_n(4);
    cs_n = 1'b0;
    wait_n(6);
    check(err_hold == 1'b1, "R3 hold flag", int'(err_hold), 1);
    check(err_setup == 1'b0, "R3 setup flag clear", int'(err_setup), 0);
    wait_n(2 * SKP + 8);
    dead_rises(8'hA7, 12);
    select_high();

    // R2: setup too short
    cs_n = 1'b0;
    wait_n(10);
    dead_rises(8'h4D, 12);
    check(err_setup == 1'b1, "R2 setup flag", int'(err_setup), 1);
    select_high();

    // R2: a correct frame still works after violations, flags stay set
    load_reply(16'h0123);
    select_low();
    run_frame(8'h2B, 5'd10, 10, 16'h0123);
    select_high();
    check(err_setup == 1'b1 && err_hold == 1'b1, "R2 R3 flags sticky",
          int'({err_setup, err_hold}), 3);
    check(expq.size() == 0, "R1 all words delivered", expq.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule